// File: doc/BRIEF.md
# Per-Pixel Indexed / True-Colour Compositor

This block turns three parallel framebuffer planes into a stream of 24-bit RGB pixels, one per clock. For each pixel position it reads an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word decides, pixel by pixel, whether the output comes straight from the direct-colour word or from a 256-entry palette lookup of the index. Indexed and true-colour pixels can therefore sit side by side on one scanline.

A single `start` pulse scans one frame. The active width and height and the colour depth are captured when the scan is accepted. Rows are walked top to bottom and pixels left to right. The plane addresses use a fixed row pitch of 1024 pixels, whatever the visible width. The index plane holds one byte per pixel. The direct and control planes hold four bytes per pixel, so their byte addresses are four times the pixel offset. The attached memories are expected to return data on the clock edge after an address is presented. The palette is written through its own port and is initialised by reset.

The pipeline has two stages: fetch, then select/lookup. Each output pixel carries a valid strobe, a start-of-row marker and an end-of-frame marker. A `done` flag reports that the frame is complete.

Top module: `pix_compositor`

## Requirements
- R1: While reset is applied (`rst_n` low, sampled on the clock) and after it ends, `pix_valid`, `fetch_en`, `busy` and `done` are low. Every palette entry is 24'h000000 except entry 255, which is 24'hFFFFFF.
- R2: When the captured depth flag is 1 and bits 31:24 of the control word equal 8'h03, the output pixel is bits 23:0 of the direct-colour word. Bits 31:24 of that word have no effect. Bits 23:0 of the control word also have no effect.
- R3: In every other case the output pixel is the palette entry selected by the 8-bit index. This includes control top bytes such as 8'h83 or 8'h02, and every pixel when the captured depth flag is 0.
- R4: For pixel (x, y), `idx_addr` = y*1024 + x, and `dir_addr` = `ctl_addr` = 4*(y*1024 + x). Pixels are fetched in row-major order with x from 0 to width-1 and y from 0 to height-1.
- R5: One pixel is fetched per cycle with no gaps. Each pixel appears on the outputs with `pix_valid` high two cycles after its address is driven with `fetch_en` high. A frame delivers exactly width*height pixels.
- R6: `pix_sol` is high only on output pixels with x = 0. `pix_eof` is high only on the last pixel of the frame.
- R7: `busy` is high from the cycle after an accepted start until the end-of-frame pixel is output. `done` goes high in the same cycle as `pix_eof` and stays high until the next accepted start, which clears it one cycle later.
- R8: A `start` pulse while `busy` is high is ignored. The current scan continues unchanged.
- R9: A palette write (`pal_we` high, entry `pal_idx`, value `pal_rgb` with red in 23:16, green in 15:8 and blue in 7:0) takes effect for lookups from the next cycle on. Output RGB uses the same field layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame scan when idle |
| cfg_width | input | 11 | Visible pixels per row, 1..1024 |
| cfg_height | input | 11 | Rows per frame, 1..1024 |
| cfg_depth24 | input | 1 | 1 enables per-pixel direct colour |
| pal_we | input | 1 | Palette write strobe |
| pal_idx | input | 8 | Palette entry to write |
| pal_rgb | input | 24 | Palette colour to write |
| fetch_en | output | 1 | Plane addresses are valid this cycle |
| idx_addr | output | 20 | Byte address in the index plane |
| dir_addr | output | 22 | Byte address in the direct-colour plane |
| ctl_addr | output | 22 | Byte address in the control plane |
| idx_data | input | 8 | Index byte, one cycle after its address |
| dir_data | input | 32 | Direct-colour word, one cycle after its address |
| ctl_data | input | 32 | Control word, one cycle after its address |
| pix_valid | output | 1 | Output pixel strobe |
| pix_rgb | output | 24 | Output colour |
| pix_sol | output | 1 | Output pixel is first of its row |
| pix_eof | output | 1 | Output pixel is last of the frame |
| busy | output | 1 | Scan or pipeline in progress |
| done | output | 1 | Frame finished, held until next start |

## Verification
The bound checker runs on every cycle. It checks that fetches happen only while busy, that addresses step by one inside a row, that every end-of-frame marker sits on a valid pixel and matches a rising `done`, that `done` holds until a start, and that no fetch occurs while `done` is high. The colour choice between direct and palette paths, the mask on the control byte, the effect of the depth flag, the palette reset values and palette writes, and the exact pixel count all depend on plane contents. Only the bench scenarios can show these, by comparing each output pixel against a model of the three planes. The same holds for a start pulse that is ignored mid-frame.

// File: rtl/pix_compositor_pkg.sv
// Package: shared constants and types for the pixel compositor.
// Assumes an 8-bit tag field at the top of the control-plane word.
package pix_compositor_pkg;

    // Control-word tag value that selects direct 24-bit colour.
    localparam logic [7:0] DIRECT_TAG = 8'h03;

    // Per-pixel side information travelling down the pipeline.
    typedef struct packed {
        logic vld;
        logic sol;
        logic eof;
    } pix_tag_t;

endpackage

// File: rtl/pix_scan_gen.sv
// Module: pix_scan_gen
// Walks a frame in row-major order and drives one pixel offset per cycle.
// Assumes: cfg_w in 1..LINE_STRIDE and cfg_h in 1..MAX_LINES when go is high.
// Captures the limits on go. The offset is y*LINE_STRIDE + x.
module pix_scan_gen
    import pix_compositor_pkg::*;
#(
    parameter int LINE_STRIDE = 1024,
    parameter int MAX_LINES   = 1024,
    localparam int X_W    = $clog2(LINE_STRIDE),
    localparam int Y_W    = $clog2(MAX_LINES),
    localparam int DIM_W  = X_W + 1,
    localparam int HDIM_W = Y_W + 1,
    localparam int PIX_AW = X_W + Y_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DIM_W-1:0]  cfg_w,
    input  logic [HDIM_W-1:0] cfg_h,
    output logic              active,
    output pix_tag_t          tag,
    output logic [PIX_AW-1:0] pix_off
);

    logic [X_W-1:0] x_q, x_lim_q;
    logic [Y_W-1:0] y_q, y_lim_q;
    logic           x_end, y_end;

    assign x_end = (x_q == x_lim_q);
    assign y_end = (y_q == y_lim_q);

    // Advance the x/y counters and capture limits when a scan is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            x_q     <= '0;
            y_q     <= '0;
            x_lim_q <= '0;
            y_lim_q <= '0;
        end else if (go) begin
            active  <= 1'b1;
            x_q     <= '0;
            y_q     <= '0;
            x_lim_q <= X_W'(cfg_w - DIM_W'(1));
            y_lim_q <= Y_W'(cfg_h - HDIM_W'(1));
        end else if (active) begin
            if (x_end) begin
                x_q <= '0;
                if (y_end) begin
                    active <= 1'b0;
                end else begin
                    y_q <= y_q + Y_W'(1);
                end
            end else begin
                x_q <= x_q + X_W'(1);
            end
        end
    end

    // Describe the pixel being fetched this cycle.
    always_comb begin
        tag.vld = active;
        tag.sol = active && (x_q == '0);
        tag.eof = active && x_end && y_end;
        pix_off = PIX_AW'(y_q) * PIX_AW'(LINE_STRIDE) + PIX_AW'(x_q);
    end

endmodule

// File: rtl/pix_palette.sv
// Module: pix_palette
// Colour lookup table with one synchronous write port and one combinational read port.
// Assumes: reset loads black into every entry and white into the last one.
module pix_palette #(
    parameter int IDX_W = 8,
    parameter int RGB_W = 24,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W-1:0] wr_rgb,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_rgb
);

    logic [RGB_W-1:0] table_q [ENTRIES];

    // Load reset colours, or store one written entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                table_q[i] <= (i == ENTRIES - 1) ? {RGB_W{1'b1}} : '0;
            end
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_rgb;
        end
    end

    // Read the addressed colour.
    assign rd_rgb = table_q[rd_idx];

endmodule

// File: rtl/pix_select.sv
// Module: pix_select
// Chooses direct colour or palette colour for one pixel.
// Assumes: the tag occupies the top byte of ctl_word. Direct colour is the low RGB_W bits.
module pix_select
    import pix_compositor_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RGB_W  = 24
) (
    input  logic              depth24,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic [WORD_W-1:0] dir_word,
    input  logic [RGB_W-1:0]  pal_rgb,
    output logic [RGB_W-1:0]  rgb
);

    logic use_direct;

    // Pick the colour source from depth mode and control tag.
    always_comb begin
        use_direct = depth24 && (ctl_word[WORD_W-1 -: 8] == DIRECT_TAG);
        rgb        = use_direct ? dir_word[RGB_W-1:0] : pal_rgb;
    end

endmodule

// File: rtl/pix_compositor.sv
// Module: pix_compositor (top)
// Two-stage compositor. Stage 1 drives plane addresses. Stage 2 receives the plane
// data one cycle later, chooses the colour and registers it on the outputs.
// Assumes: each plane memory returns data on the edge after the address.
// Assumes: configuration is stable when start is accepted.
module pix_compositor
    import pix_compositor_pkg::*;
#(
    parameter int LINE_STRIDE = 1024,
    parameter int MAX_LINES   = 1024,
    parameter int IDX_W       = 8,
    parameter int WORD_W      = 32,
    parameter int RGB_W       = 24,
    localparam int X_W    = $clog2(LINE_STRIDE),
    localparam int Y_W    = $clog2(MAX_LINES),
    localparam int DIM_W  = X_W + 1,
    localparam int HDIM_W = Y_W + 1,
    localparam int PIX_AW = X_W + Y_W,
    localparam int WRD_AW = PIX_AW + $clog2(WORD_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [HDIM_W-1:0] cfg_height,
    input  logic              cfg_depth24,
    input  logic              pal_we,
    input  logic [IDX_W-1:0]  pal_idx,
    input  logic [RGB_W-1:0]  pal_rgb,
    output logic              fetch_en,
    output logic [PIX_AW-1:0] idx_addr,
    output logic [WRD_AW-1:0] dir_addr,
    output logic [WRD_AW-1:0] ctl_addr,
    input  logic [IDX_W-1:0]  idx_data,
    input  logic [WORD_W-1:0] dir_data,
    input  logic [WORD_W-1:0] ctl_data,
    output logic              pix_valid,
    output logic [RGB_W-1:0]  pix_rgb,
    output logic              pix_sol,
    output logic              pix_eof,
    output logic              busy,
    output logic              done
);

    localparam int WORD_SHIFT = $clog2(WORD_W / 8);

    logic              go;
    logic              scan_active;
    pix_tag_t          scan_tag;
    pix_tag_t          s2_tag;
    logic [PIX_AW-1:0] pix_off;
    logic              depth_q;
    logic [RGB_W-1:0]  lut_rgb;
    logic [RGB_W-1:0]  sel_rgb;

    assign busy = scan_active || s2_tag.vld;
    assign go   = start && !busy;

    pix_scan_gen #(
        .LINE_STRIDE(LINE_STRIDE),
        .MAX_LINES  (MAX_LINES)
    ) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .cfg_w  (cfg_width),
        .cfg_h  (cfg_height),
        .active (scan_active),
        .tag    (scan_tag),
        .pix_off(pix_off)
    );

    // Form byte addresses for the three planes.
    always_comb begin
        fetch_en = scan_tag.vld;
        idx_addr = pix_off;
        dir_addr = WRD_AW'(pix_off) << WORD_SHIFT;
        ctl_addr = WRD_AW'(pix_off) << WORD_SHIFT;
    end

    pix_palette #(
        .IDX_W(IDX_W),
        .RGB_W(RGB_W)
    ) u_palette (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (pal_we),
        .wr_idx(pal_idx),
        .wr_rgb(pal_rgb),
        .rd_idx(idx_data),
        .rd_rgb(lut_rgb)
    );

    pix_select #(
        .WORD_W(WORD_W),
        .RGB_W (RGB_W)
    ) u_select (
        .depth24 (depth_q),
        .ctl_word(ctl_data),
        .dir_word(dir_data),
        .pal_rgb (lut_rgb),
        .rgb     (sel_rgb)
    );

    // Capture the depth mode for the frame being launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= 1'b0;
        end else if (go) begin
            depth_q <= cfg_depth24;
        end
    end

    // Carry pixel markers alongside the fetch, aligned with returning data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_tag <= '0;
        end else begin
            s2_tag <= scan_tag;
        end
    end

    // Register the chosen colour and markers onto the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_sol   <= 1'b0;
            pix_eof   <= 1'b0;
            pix_rgb   <= '0;
        end else begin
            pix_valid <= s2_tag.vld;
            pix_sol   <= s2_tag.vld && s2_tag.sol;
            pix_eof   <= s2_tag.vld && s2_tag.eof;
            if (s2_tag.vld) begin
                pix_rgb <= sel_rgb;
            end
        end
    end

    // Raise done with the last pixel; clear it when a new scan starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (go) begin
            done <= 1'b0;
        end else if (s2_tag.vld && s2_tag.eof) begin
            done <= 1'b1;
        end
    end

endmodule

// File: rtl/pix_compositor_chk.sv
// Module: pix_compositor_chk
// Cycle-level properties of the compositor, attached to the top by bind.
module pix_compositor_chk #(
    parameter int LINE_STRIDE = 1024,
    parameter int PIX_AW      = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              fetch_en,
    input logic [PIX_AW-1:0] idx_addr,
    input logic              pix_valid,
    input logic              pix_eof,
    input logic              busy,
    input logic              done
);

    AST_FETCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |-> busy); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && $past(fetch_en) && (idx_addr % LINE_STRIDE) != 0)
            |-> idx_addr == $past(idx_addr) + PIX_AW'(1)); // R4

    AST_EOF_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eof |-> pix_valid); // R6

    AST_DONE_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> pix_eof); // R7

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R7

    AST_NO_FETCH_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fetch_en); // R5

endmodule

bind pix_compositor pix_compositor_chk #(
    .LINE_STRIDE(LINE_STRIDE),
    .PIX_AW     (PIX_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fetch_en (fetch_en),
    .idx_addr (idx_addr),
    .pix_valid(pix_valid),
    .pix_eof  (pix_eof),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_pix_compositor.sv
// Directed bench: one task per scenario, plane memories modelled as functions of address.
module test_pix_compositor;

    localparam int CLK_PERIOD = 10;
    localparam int STRIDE     = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] cfg_width = 11'd1;
    logic [10:0] cfg_height = 11'd1;
    logic        cfg_depth24 = 1'b0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_idx = '0;
    logic [23:0] pal_rgb = '0;
    logic        fetch_en;
    logic [19:0] idx_addr;
    logic [21:0] dir_addr, ctl_addr;
    logic [7:0]  idx_data = '0;
    logic [31:0] dir_data = '0, ctl_data = '0;
    logic        pix_valid, pix_sol, pix_eof, busy, done;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    int pat    = 0;
    bit finished = 1'b0;
    logic [23:0] pal_m [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pix_compositor i_pix_compositor (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_depth24(cfg_depth24),
        .pal_we(pal_we), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
        .fetch_en(fetch_en), .idx_addr(idx_addr), .dir_addr(dir_addr), .ctl_addr(ctl_addr),
        .idx_data(idx_data), .dir_data(dir_data), .ctl_data(ctl_data),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb), .pix_sol(pix_sol),
        .pix_eof(pix_eof), .busy(busy), .done(done)
    );

    function automatic logic [7:0] m_idx(int a);
        if (pat == 0) return a[0] ? 8'hFF : 8'h00;
        return 8'(a * 37 + (a >> 10) * 11);
    endfunction

    function automatic logic [31:0] m_ctl(int a);
        if (pat == 0) return 32'h0;
        case (a % 4)
            0:       return {8'h03, 24'(a * 13)};
            1:       return {8'h83, 24'(a * 5)};
            2:       return {8'h02, 24'hFFFFFF};
            default: return {8'h03, 24'h0};
        endcase
    endfunction

    function automatic logic [31:0] m_dir(int a);
        return {8'(a ^ 8'h5C), 24'(a * 24'h010203 + 24'h0A0B0C)};
    endfunction

    // Plane memories: data appears on the edge after the address.
    always @(posedge clk) begin
        if (fetch_en) begin
            idx_data <= m_idx(int'(idx_addr));
            ctl_data <= m_ctl(int'(ctl_addr >> 2));
            dir_data <= m_dir(int'(dir_addr >> 2));
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!pix_valid && !fetch_en, "R1 outputs idle in reset", {pix_valid, fetch_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !pix_valid, "R1 idle after reset", {busy, done, pix_valid}, 0);
        for (int i = 0; i < 256; i++) pal_m[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
    endtask

    task automatic t_pal_write(input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            pal_we  = 1'b1;
            pal_idx = 8'(i);
            pal_rgb = {8'(i), 8'(~i), 8'(i ^ 8'h5A)};
            pal_m[i] = pal_rgb;
            @(negedge clk);
        end
        pal_we = 1'b0;
    endtask

    // Run one frame, checking addresses, order, colours, markers, count and done.
    task automatic t_frame(input int w, input int h, input bit d24, input int p,
                           input int poke, input string tag);
        int fx = 0, fy = 0, ox = 0, oy = 0, n = 0, cyc = 0;
        int ea;
        bit addr_ok = 1'b1, fetch_seen = 1'b0;
        logic [23:0] exp_rgb;
        logic [31:0] cw;
        pat = p;
        cfg_width = 11'(w);
        cfg_height = 11'(h);
        cfg_depth24 = d24;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, {tag, " R7 busy after start"}, {busy, done}, 2'b10);
        while (1) begin
            start = (cyc == poke) ? 1'b1 : 1'b0;
            if (fetch_en) begin
                ea = fy * STRIDE + fx;
                fetch_seen = 1'b1;
                if (int'(idx_addr) != ea || int'(dir_addr) != 4 * ea || int'(ctl_addr) != 4 * ea) begin
                    addr_ok = 1'b0;
                    check(0, {tag, " R4 address"}, idx_addr, ea);
                end
                if (fx == w - 1) begin fx = 0; fy++; end else fx++;
            end else if (fetch_seen && fy < h) begin
                check(0, {tag, " R5 fetch gap"}, fy, h);
            end
            if (pix_valid) begin
                ea = oy * STRIDE + ox;
                cw = m_ctl(ea);
                exp_rgb = (d24 && cw[31:24] == 8'h03) ? m_dir(ea)[23:0] : pal_m[m_idx(ea)];
                check(pix_rgb == exp_rgb,
                      {tag, (d24 && cw[31:24] == 8'h03) ? " R2 direct colour" : " R3 palette colour"},
                      pix_rgb, exp_rgb);
                check(pix_sol == (ox == 0), {tag, " R6 start-of-row"}, pix_sol, ox == 0);
                check(pix_eof == (ox == w - 1 && oy == h - 1), {tag, " R6 end-of-frame"},
                      pix_eof, (ox == w - 1 && oy == h - 1));
                n++;
                if (pix_eof) begin
                    check(done, {tag, " R7 done with eof"}, done, 1);
                    break;
                end
                if (ox == w - 1) begin ox = 0; oy++; end else ox++;
            end
            cyc++;
            if (cyc > w * h + 20) begin
                check(0, {tag, " R5 frame never ended"}, n, w * h);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(n == w * h, {tag, " R5 pixel count"}, n, w * h);
        check(addr_ok, {tag, " R4 addresses"}, addr_ok, 1);
        repeat (3) @(negedge clk);
        check(done && !busy && !pix_valid, {tag, " R7 done held idle"}, {done, busy, pix_valid}, 3'b100);
    endtask

    initial begin
        t_reset();
        t_frame(4, 2, 1'b0, 0, -1, "reset palette R1");
        t_pal_write(0, 255);
        t_frame(6, 3, 1'b1, 1, -1, "mixed R2");
        t_frame(6, 3, 1'b0, 1, -1, "depth8 R3");
        t_frame(1, 1, 1'b1, 1, -1, "single pixel R6");
        t_frame(1024, 2, 1'b1, 1, -1, "full stride R4");
        t_frame(5, 4, 1'b1, 1, 7, "start while busy R8");
        t_pal_write(255, 1);
        t_frame(8, 2, 1'b0, 1, -1, "palette rewrite R9");
        finish_run();
    end

endmodule